// File: doc/BRIEF.md
# Interlaced 819-Line Raster Timing Generator

This block produces every timing signal needed to draw a two-field interlaced, 819-line monochrome raster. It is clocked directly at 50 MHz, with one pixel per clock. A pixel counter steps across each line. A line counter steps through the frame. From those two counts the block derives a horizontal sync, a vertical sync, an active-picture enable, a field flag and a combined sync output. Driven into a video output stage, these give a correctly timed black picture. Later pixel logic can use the enable and the field flag to gate its own data.

The two fields are offset by half a line. The first field's vertical sync fills line 0. The second field's vertical sync starts at the middle of the last line of field one and ends at the middle of the following line. Each field has a fixed window of picture lines. Every count is a parameter, so line length, sync width, porches and line windows can be retuned without editing the logic. All outputs leave flip-flops, and the only reset is synchronous.

Top module: `raster819_timing`

## Requirements
- R1: The pixel count runs 0 to H_TOTAL-1 and wraps. `hsync_n` is 0 exactly while the pixel count is below HSYNC_END, and 1 otherwise.
- R2: The line count advances when the pixel count wraps. It runs 0 to V_TOTAL-1 (default 818) and then returns to 0, so one frame lasts H_TOTAL*V_TOTAL clocks.
- R3: `vsync_n` is 0 for the whole of line 0. This is the first field's vertical sync.
- R4: `vsync_n` is 0 from pixel H_TOTAL/2 of line F1_END_LINE (default 409) up to pixel H_TOTAL/2-1 of line F1_END_LINE+1. This is the second field's sync, offset by half a line. At all other times outside line 0, `vsync_n` is 1.
- R5: `field_odd` is 1 from the start of line 0 until pixel H_TOTAL/2 of line F1_END_LINE. It is 0 from there until the frame wraps.
- R6: In the first field, `video_en` can be 1 only on lines F1_ACT_FIRST..F1_ACT_LAST (default 39..406).
- R7: In the second field, `video_en` can be 1 only on lines F2_ACT_FIRST..F2_ACT_LAST (default 447..816).
- R8: On an active line, `video_en` is 1 exactly when HACT_START <= pixel count < HACT_END.
- R9: `csync` always equals `hsync_n | vsync_n`. No picture content is added.
- R10: While `rst` is 1 at a clock edge, the counts go to pixel 0, line 0. The outputs then show that position: `hsync_n`=0, `vsync_n`=0, `video_en`=0, `field_odd`=1, `csync`=0. Counting restarts from there on the first edge after `rst` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_n | output | 1 | Horizontal sync, low during the sync tip |
| vsync_n | output | 1 | Vertical sync, low during a field sync |
| video_en | output | 1 | High on active picture pixels |
| field_odd | output | 1 | 1 in the first field, 0 in the second |
| csync | output | 1 | OR of the horizontal and vertical sync outputs |

## Verification
Every output is a decode of the two counters, so a corrupted pixel or line count shows at the ports within one clock. It appears as an `hsync_n` edge at the wrong pixel, or as a field flag or enable edge on the wrong line. The bench predicts all five outputs from the clock count since reset, using arithmetic alone. It sweeps two complete frames of a shortened raster, so every line and pixel position is compared. A slip in the half-line field switch shows up on the first frame as a wrong `vsync_n` or `field_odd` at the middle of the boundary line.

// File: rtl/raster819_pkg.sv
package raster819_pkg;

    typedef struct packed {
        logic hsync_n;
        logic vsync_n;
        logic video_en;
        logic field_odd;
        logic csync;
    } raster_sig_t;

endpackage

// File: rtl/raster_hstep.sv
module raster_hstep #(
    parameter int H_TOTAL = 2442,
    localparam int HW = $clog2(H_TOTAL)
) (
    input  logic [HW-1:0] h_i,
    output logic [HW-1:0] h_o,
    output logic          wrap_o
);
    localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);

    always_comb begin
        wrap_o = (h_i == H_LAST);
        h_o    = wrap_o ? '0 : h_i + 1'b1;
    end
endmodule

// File: rtl/raster_vstep.sv
module raster_vstep #(
    parameter int V_TOTAL = 819,
    localparam int VW = $clog2(V_TOTAL)
) (
    input  logic [VW-1:0] v_i,
    input  logic          adv_i,
    output logic [VW-1:0] v_o
);
    localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

    always_comb begin
        if (!adv_i)              v_o = v_i;
        else if (v_i == V_LAST)  v_o = '0;
        else                     v_o = v_i + 1'b1;
    end
endmodule

// File: rtl/raster_decode.sv
module raster_decode
    import raster819_pkg::*;
#(
    parameter int H_TOTAL      = 2442,
    parameter int HSYNC_END    = 63,
    parameter int HACT_START   = 190,
    parameter int HACT_END     = 2400,
    parameter int V_TOTAL      = 819,
    parameter int F1_ACT_FIRST = 39,
    parameter int F1_ACT_LAST  = 406,
    parameter int F1_END_LINE  = 409,
    parameter int F2_ACT_FIRST = 447,
    parameter int F2_ACT_LAST  = 816,
    localparam int HW = $clog2(H_TOTAL),
    localparam int VW = $clog2(V_TOTAL)
) (
    input  logic [HW-1:0] h_i,
    input  logic [VW-1:0] v_i,
    output raster_sig_t   sig_o
);
    localparam logic [HW-1:0] HS_END  = HW'(HSYNC_END);
    localparam logic [HW-1:0] HA_LO   = HW'(HACT_START);
    localparam logic [HW-1:0] HA_HI   = HW'(HACT_END);
    localparam logic [HW-1:0] HALF    = HW'(H_TOTAL / 2);
    localparam logic [VW-1:0] A1_LO   = VW'(F1_ACT_FIRST);
    localparam logic [VW-1:0] A1_HI   = VW'(F1_ACT_LAST);
    localparam logic [VW-1:0] A2_LO   = VW'(F2_ACT_FIRST);
    localparam logic [VW-1:0] A2_HI   = VW'(F2_ACT_LAST);
    localparam logic [VW-1:0] SWITCH  = VW'(F1_END_LINE);
    localparam logic [VW-1:0] SWITCH1 = VW'(F1_END_LINE + 1);

    logic first_half, line_in_win, pix_in_win, vs_f1, vs_f2;

    always_comb begin
        first_half   = (h_i < HALF);
        vs_f1        = (v_i == '0);
        vs_f2        = ((v_i == SWITCH) && !first_half) ||
                       ((v_i == SWITCH1) && first_half);
        line_in_win  = ((v_i >= A1_LO) && (v_i <= A1_HI)) ||
                       ((v_i >= A2_LO) && (v_i <= A2_HI));
        pix_in_win   = (h_i >= HA_LO) && (h_i < HA_HI);

        sig_o.hsync_n   = (h_i >= HS_END);
        sig_o.vsync_n   = !(vs_f1 || vs_f2);
        sig_o.video_en  = line_in_win && pix_in_win;
        sig_o.field_odd = (v_i < SWITCH) || ((v_i == SWITCH) && first_half);
        sig_o.csync     = sig_o.hsync_n | sig_o.vsync_n;
    end
endmodule

// File: rtl/raster819_timing.sv
module raster819_timing
    import raster819_pkg::*;
#(
    parameter int H_TOTAL      = 2442,
    parameter int HSYNC_END    = 63,
    parameter int HACT_START   = 190,
    parameter int HACT_END     = 2400,
    parameter int V_TOTAL      = 819,
    parameter int F1_ACT_FIRST = 39,
    parameter int F1_ACT_LAST  = 406,
    parameter int F1_END_LINE  = 409,
    parameter int F2_ACT_FIRST = 447,
    parameter int F2_ACT_LAST  = 816,
    localparam int HW = $clog2(H_TOTAL),
    localparam int VW = $clog2(V_TOTAL)
) (
    input  logic clk,
    input  logic rst,
    output logic hsync_n,
    output logic vsync_n,
    output logic video_en,
    output logic field_odd,
    output logic csync
);
    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
        raster_sig_t   sig;
    } state_t;

    state_t        state_d, state_q;
    logic [HW-1:0] h_step, h_d;
    logic [VW-1:0] v_step, v_d;
    logic          h_wrap;
    raster_sig_t   sig_d;

    raster_hstep #(.H_TOTAL(H_TOTAL)) u_hstep (
        .h_i(state_q.h), .h_o(h_step), .wrap_o(h_wrap)
    );

    raster_vstep #(.V_TOTAL(V_TOTAL)) u_vstep (
        .v_i(state_q.v), .adv_i(h_wrap), .v_o(v_step)
    );

    // Next position: reset forces pixel 0 of line 0
    always_comb begin
        h_d = rst ? '0 : h_step;
        v_d = rst ? '0 : v_step;
    end

    // Outputs are decoded from the next position so they line up with the counts
    raster_decode #(
        .H_TOTAL(H_TOTAL), .HSYNC_END(HSYNC_END),
        .HACT_START(HACT_START), .HACT_END(HACT_END),
        .V_TOTAL(V_TOTAL),
        .F1_ACT_FIRST(F1_ACT_FIRST), .F1_ACT_LAST(F1_ACT_LAST),
        .F1_END_LINE(F1_END_LINE),
        .F2_ACT_FIRST(F2_ACT_FIRST), .F2_ACT_LAST(F2_ACT_LAST)
    ) u_decode (
        .h_i(h_d), .v_i(v_d), .sig_o(sig_d)
    );

    assign state_d = '{h: h_d, v: v_d, sig: sig_d};

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    logic [HW-1:0] h_q;
    logic [VW-1:0] v_q;
    assign h_q = state_q.h;
    assign v_q = state_q.v;

    assign hsync_n   = state_q.sig.hsync_n;
    assign vsync_n   = state_q.sig.vsync_n;
    assign video_en  = state_q.sig.video_en;
    assign field_odd = state_q.sig.field_odd;
    assign csync     = state_q.sig.csync;
endmodule

// File: rtl/raster819_checks.sv
module raster819_checks #(
    parameter int H_TOTAL     = 2442,
    parameter int V_TOTAL     = 819,
    parameter int F1_END_LINE = 409,
    localparam int HW = $clog2(H_TOTAL),
    localparam int VW = $clog2(V_TOTAL)
) (
    input logic          clk,
    input logic          rst,
    input logic [HW-1:0] h_q,
    input logic [VW-1:0] v_q,
    input logic          hsync_n,
    input logic          vsync_n,
    input logic          video_en,
    input logic          field_odd,
    input logic          csync
);
    localparam logic [HW-1:0] HALF   = HW'(H_TOTAL / 2);
    localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
    localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
    localparam logic [VW-1:0] SWITCH = VW'(F1_END_LINE);

    // R1
    h_range_chk: assert property (@(posedge clk) disable iff (rst)
        h_q <= H_LAST);

    // R2
    v_range_chk: assert property (@(posedge clk) disable iff (rst)
        v_q <= V_LAST);

    // R1
    hsync_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hsync_n) |-> (h_q == '0));

    // R5
    field_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(field_odd) |-> (h_q == '0 && v_q == '0));

    // R5
    field_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(field_odd) |-> (h_q == HALF && v_q == SWITCH));

    // R8
    active_clear_chk: assert property (@(posedge clk) disable iff (rst)
        video_en |-> (hsync_n && vsync_n));

    // R9
    csync_low_chk: assert property (@(posedge clk) disable iff (rst)
        !csync |-> (!hsync_n && !vsync_n));
endmodule

bind raster819_timing raster819_checks #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .F1_END_LINE(F1_END_LINE)
) u_checks (
    .clk(clk), .rst(rst), .h_q(h_q), .v_q(v_q),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .video_en(video_en),
    .field_odd(field_odd), .csync(csync)
);

// File: tb/tb_raster819_timing.sv
module tb_raster819_timing;
    localparam int H   = 20;
    localparam int HSE = 3;
    localparam int HAS = 5;
    localparam int HAE = 17;
    localparam int V   = 21;
    localparam int A1L = 3;
    localparam int A1H = 8;
    localparam int SW  = 10;
    localparam int A2L = 13;
    localparam int A2H = 19;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hsync_n, vsync_n, video_en, field_odd, csync;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    raster819_timing #(
        .H_TOTAL(H), .HSYNC_END(HSE), .HACT_START(HAS), .HACT_END(HAE),
        .V_TOTAL(V), .F1_ACT_FIRST(A1L), .F1_ACT_LAST(A1H),
        .F1_END_LINE(SW), .F2_ACT_FIRST(A2L), .F2_ACT_LAST(A2H)
    ) dut (
        .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .video_en(video_en), .field_odd(field_odd), .csync(csync)
    );

    task automatic check(input logic got, input logic exp, input string tag, input int k);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s at step %0d: got %b expected %b", tag, k, got, exp);
        end
    endtask

    // Compare every output against the arithmetic model for step k after reset
    task automatic check_step(input int k);
        int h, v;
        logic e_hs, e_vs, e_en, e_fo;
        h    = k % H;
        v    = (k / H) % V;
        e_hs = (h >= HSE);
        e_vs = !((v == 0) || (v == SW && h >= H/2) || (v == SW+1 && h < H/2));
        e_fo = (v < SW) || (v == SW && h < H/2);
        e_en = (((v >= A1L) && (v <= A1H)) || ((v >= A2L) && (v <= A2H)))
               && (h >= HAS) && (h < HAE);
        check(hsync_n, e_hs, "R1 hsync_n", k);
        if (v == 0)
            check(vsync_n, e_vs, "R3 vsync_n line0", k);
        else if (v == SW || v == SW+1)
            check(vsync_n, e_vs, "R4 vsync_n half-line", k);
        else
            check(vsync_n, e_vs, "R2 vsync_n frame", k);
        check(field_odd, e_fo, "R5 field_odd", k);
        if (v <= SW)
            check(video_en, e_en, "R6 R8 video_en field1", k);
        else
            check(video_en, e_en, "R7 R8 video_en field2", k);
        check(csync, e_hs | e_vs, "R9 csync", k);
    endtask

    task automatic check_reset_state();
        check(hsync_n,   1'b0, "R10 reset hsync_n",   0);
        check(vsync_n,   1'b0, "R10 reset vsync_n",   0);
        check(video_en,  1'b0, "R10 reset video_en",  0);
        check(field_odd, 1'b1, "R10 reset field_odd", 0);
        check(csync,     1'b0, "R10 reset csync",     0);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        // Sweep two full frames plus a little
        for (int k = 0; k < 2 * H * V + 7; k++) begin
            check_step(k);
            @(posedge clk);
            @(negedge clk);
        end
        // Reset in mid frame: R10
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        for (int k = 0; k < H * (SW + 3); k++) begin
            check_step(k);
            @(posedge clk);
            @(negedge clk);
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule